// File: doc/BRIEF.md
# Shared-Cache Interference Miss Monitor

This block watches the access stream of a cache that several cores share. It estimates how many of each core's misses happen only because the other cores also use that cache. For every core it keeps a shadow directory that holds tags only. The shadow directory has the same sets, the same ways and the same least-recently-used replacement as the real cache. Only the owning core's accesses update it, so it tracks what the cache would hold if that core ran alone.

On each valid access the monitor looks up the requesting core's shadow directory and compares the result with the hit or miss flag reported by the real cache. Three outcomes are possible:
- The real cache hits. Nothing is counted.
- The real cache misses and the shadow directory also misses. This is a private-mode miss. Nothing is counted.
- The real cache misses but the shadow directory hits. This is an interference miss. The core's miss counter goes up by one, and its cycle accumulator grows by the miss penalty presented on an input.

A line that another core pushes out of the real cache is therefore charged only when the owning core comes back for it and its shadow directory still holds it. A scheduler or a profiling agent reads the per-core totals and uses them to judge how much the cores slow each other down.

Top module: `shcache_intf_mon`

## Requirements
- R1: A synchronous `rst` or `clr` sets every miss counter and cycle accumulator to zero one cycle later and invalidates every shadow tag. After a clear, an access to a line that was held before finds no shadow hit.
- R2: A valid access with `sc_hit`=0 whose line is present in the requesting core's shadow directory is an interference miss. On the clock edge that samples the access, that core's miss counter increments by one and its accumulator adds `miss_penalty`.
- R3: A valid access with `sc_hit`=0 whose line is absent from the requesting core's shadow directory is a private-mode miss. It changes no counter, and it allocates the line into that shadow directory.
- R4: A valid access with `sc_hit`=1 never changes any counter. It only refreshes the recency of the line in the shadow directory.
- R5: A core's shadow directory is updated only by accesses carrying that core's ID. A line brought in by core 1 gives core 0 no shadow hit.
- R6: Each shadow set uses true LRU over `WAYS` ways. A miss into a full set evicts the least recently used way, and a hit makes the line most recent.
- R7: Shadow sets are independent. Filling one set beyond `WAYS` lines does not evict a line held in a different set.
- R8: The penalty is taken from `miss_penalty` in the cycle of the interfering access. Changing it later leaves the accumulated totals unchanged.
- R9: While `acc_valid` is 0, the other access inputs are ignored. Counters stay as they are and no shadow tag is allocated.
- R10: Address split with the defaults: `acc_addr[3:0]` is the byte offset and is ignored, `acc_addr[7:4]` selects the set, and `acc_addr[15:8]` is the tag. Two addresses in the same line therefore match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of counters and shadow tags |
| acc_valid | input | 1 | Access strobe for the current cycle |
| acc_core | input | CORE_W (2) | ID of the requesting core |
| acc_addr | input | ADDR_W (16) | Byte address of the access |
| sc_hit | input | 1 | Real shared cache hit (1) or miss (0) |
| miss_penalty | input | PEN_W (8) | Cycles charged per interference miss |
| intf_miss_cnt | output | NUM_CORES*CNT_W (64) | Per-core interference miss counts, core c at bits [c*CNT_W +: CNT_W] |
| intf_cycles | output | NUM_CORES*ACC_W (96) | Per-core interference cycle totals, core c at bits [c*ACC_W +: ACC_W] |

## Verification
A wrong shadow-directory state cannot be seen when the access that corrupts it happens. It shows up only later, when that core misses in the real cache on an affected line. At that point a missing or extra count appears on the port one cycle after the access. For this reason the stimulus replays lines after evictions, after touches that reorder recency, after accesses from foreign cores and after a clear, so that every kind of tag or LRU corruption is turned into a count difference. A wrong penalty or a stray counter update shows directly on the outputs one edge after the access.

// File: rtl/shim_pkg.sv
package shim_pkg;

  // Outcome of one access, comparing the real cache with the private shadow
  typedef enum logic [1:0] {
    OUT_IDLE     = 2'd0,
    OUT_SHARED   = 2'd1,  // real cache hit
    OUT_PRIVATE  = 2'd2,  // miss in both structures
    OUT_INTERF   = 2'd3   // real miss, shadow hit
  } outcome_e;

endpackage

// File: rtl/ctd_shadow_dir.sv
module ctd_shadow_dir #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int WAY_W = AGE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             upd,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  output logic             hit_o
);

  logic [TAG_W-1:0] tag_mem [SETS][WAYS];
  logic [WAYS-1:0]  vld     [SETS];
  logic [AGE_W-1:0] age     [SETS][WAYS];

  logic [WAYS-1:0]  hit_vec;
  logic [WAYS-1:0]  old_vec;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] victim;
  logic [AGE_W-1:0] hit_age;

  always_comb begin
    hit_way = '0;
    victim  = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld[idx][w] && (tag_mem[idx][w] == tag);
      old_vec[w] = (age[idx][w] == AGE_W'(WAYS - 1));
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (old_vec[w]) victim  = WAY_W'(w);
    end
    hit_age = age[idx][hit_way];
  end

  assign hit_o = |hit_vec;

  // Tag storage: no reset, single write port, friendly to RAM inference
  always_ff @(posedge clk) begin
    if (upd && !hit_o) tag_mem[idx][victim] <= tag;
  end

  // Valid bits and recency ages
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        for (int w = 0; w < WAYS; w++) age[s][w] <= AGE_W'(w);
      end
    end else if (upd) begin
      for (int w = 0; w < WAYS; w++) begin
        if (hit_o) begin
          if (WAY_W'(w) == hit_way)         age[idx][w] <= '0;
          else if (age[idx][w] < hit_age)   age[idx][w] <= age[idx][w] + 1'b1;
        end else begin
          if (WAY_W'(w) == victim) begin
            age[idx][w] <= '0;
            vld[idx][w] <= 1'b1;
          end else begin
            age[idx][w] <= age[idx][w] + 1'b1;
          end
        end
      end
    end
  end

  // R6: exactly one way of the looked-up set is the LRU candidate
  lru_single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(old_vec) == 1);

  // R6: a tag is never held twice in one set
  no_dup_tag_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

endmodule

// File: rtl/ctd_tally.sv
module ctd_tally #(
  parameter int CNT_W = 16,
  parameter int ACC_W = 24,
  parameter int PEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bump,
  input  logic [PEN_W-1:0] pen,
  output logic [CNT_W-1:0] cnt_o,
  output logic [ACC_W-1:0] cyc_o
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_o <= '0;
      cyc_o <= '0;
    end else if (bump) begin
      cnt_o <= cnt_o + 1'b1;
      cyc_o <= cyc_o + ACC_W'(pen);
    end
  end

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (cnt_o == '0) && (cyc_o == '0));

  // R2
  bump_step_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bump) && !$past(clr) && !$past(rst)
      |-> (cnt_o == $past(cnt_o) + 1'b1) && (cyc_o == $past(cyc_o) + ACC_W'($past(pen))));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bump) && !$past(clr) && !$past(rst) |-> $stable(cnt_o) && $stable(cyc_o));

endmodule

// File: rtl/shcache_intf_mon.sv
module shcache_intf_mon
  import shim_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int SETS      = 16,
  parameter int WAYS      = 4,
  parameter int ADDR_W    = 16,
  parameter int OFF_W     = 4,
  parameter int PEN_W     = 8,
  parameter int CNT_W     = 16,
  parameter int ACC_W     = 24,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int IDX_W    = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       acc_valid,
  input  logic [CORE_W-1:0]          acc_core,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic                       sc_hit,
  input  logic [PEN_W-1:0]           miss_penalty,
  output logic [NUM_CORES*CNT_W-1:0] intf_miss_cnt,
  output logic [NUM_CORES*ACC_W-1:0] intf_cycles
);

  logic [IDX_W-1:0]     set_idx;
  logic [TAG_W-1:0]     line_tag;
  logic [NUM_CORES-1:0] aux_hit;
  logic [NUM_CORES-1:0] bump;
  outcome_e             outcome;

  assign set_idx  = acc_addr[OFF_W +: IDX_W];
  assign line_tag = acc_addr[ADDR_W-1 -: TAG_W];

  always_comb begin
    if (!acc_valid)              outcome = OUT_IDLE;
    else if (sc_hit)             outcome = OUT_SHARED;
    else if (aux_hit[acc_core])  outcome = OUT_INTERF;
    else                         outcome = OUT_PRIVATE;
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic own;
    assign own     = acc_valid && (acc_core == CORE_W'(c));
    assign bump[c] = own && (outcome == OUT_INTERF);

    ctd_shadow_dir #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_dir (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .upd  (own),
      .idx  (set_idx),
      .tag  (line_tag),
      .hit_o(aux_hit[c])
    );

    ctd_tally #(.CNT_W(CNT_W), .ACC_W(ACC_W), .PEN_W(PEN_W)) u_tally (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .bump (bump[c]),
      .pen  (miss_penalty),
      .cnt_o(intf_miss_cnt[c*CNT_W +: CNT_W]),
      .cyc_o(intf_cycles[c*ACC_W +: ACC_W])
    );
  end

  // R4
  shared_hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && sc_hit && !clr |=> $stable(intf_miss_cnt) && $stable(intf_cycles));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_valid && !clr |=> $stable(intf_miss_cnt) && $stable(intf_cycles));

  // R5
  single_core_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bump));

endmodule

// File: tb/sim_shcache_intf_mon.sv
module sim_shcache_intf_mon;

  localparam int NC = 4;
  localparam int CW = 16;
  localparam int AW = 24;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst, clr, acc_valid, sc_hit;
  logic [1:0]  acc_core;
  logic [15:0] acc_addr;
  logic [7:0]  miss_penalty;
  logic [NC*CW-1:0] intf_miss_cnt;
  logic [NC*AW-1:0] intf_cycles;

  int checks = 0;
  int errors = 0;
  int exp_cnt [NC];
  int exp_cyc [NC];

  always #2 clk = ~clk;

  shcache_intf_mon u0 (
    .clk(clk), .rst(rst), .clr(clr), .acc_valid(acc_valid), .acc_core(acc_core),
    .acc_addr(acc_addr), .sc_hit(sc_hit), .miss_penalty(miss_penalty),
    .intf_miss_cnt(intf_miss_cnt), .intf_cycles(intf_cycles)
  );

  // {core, addr, shared hit, expected interference}
  localparam logic [19:0] VECS [NV] = '{
    {2'd0, 16'h0110, 1'b0, 1'b0},  // R3 cold miss
    {2'd0, 16'h0118, 1'b1, 1'b0},  // R4 R10 same line, other offset
    {2'd0, 16'h0110, 1'b0, 1'b1},  // R2
    {2'd1, 16'h0110, 1'b0, 1'b0},  // R5 foreign core cold
    {2'd1, 16'h0110, 1'b0, 1'b1},  // R5 own line now
    {2'd2, 16'h0120, 1'b0, 1'b0},  // R6 fill A
    {2'd2, 16'h0220, 1'b0, 1'b0},  // R6 fill B
    {2'd2, 16'h0320, 1'b0, 1'b0},  // R6 fill C
    {2'd2, 16'h0420, 1'b0, 1'b0},  // R6 fill D
    {2'd2, 16'h0520, 1'b0, 1'b0},  // R6 E evicts A
    {2'd2, 16'h0120, 1'b0, 1'b0},  // R6 A gone, evicts B
    {2'd2, 16'h0320, 1'b1, 1'b0},  // R6 touch C
    {2'd2, 16'h0620, 1'b0, 1'b0},  // R6 F evicts D
    {2'd2, 16'h0320, 1'b0, 1'b1},  // R6 C kept
    {2'd2, 16'h0420, 1'b0, 1'b0},  // R6 D was evicted
    {2'd3, 16'h0130, 1'b0, 1'b0},  // R7 set 3 line
    {2'd3, 16'h0140, 1'b0, 1'b0},  // R7 set 4 fill
    {2'd3, 16'h0240, 1'b0, 1'b0},
    {2'd3, 16'h0340, 1'b0, 1'b0},
    {2'd3, 16'h0440, 1'b0, 1'b0},
    {2'd3, 16'h0540, 1'b0, 1'b0},  // R7 set 4 overflow
    {2'd3, 16'h0130, 1'b0, 1'b1}   // R7 set 3 untouched
  };

  task automatic check_all(input string req);
    for (int c = 0; c < NC; c++) begin
      checks++;
      if (int'(intf_miss_cnt[c*CW +: CW]) != exp_cnt[c]) begin
        errors++;
        $display("FAIL %s core%0d count: got %0d expected %0d", req, c,
                 intf_miss_cnt[c*CW +: CW], exp_cnt[c]);
      end
      checks++;
      if (int'(intf_cycles[c*AW +: AW]) != exp_cyc[c]) begin
        errors++;
        $display("FAIL %s core%0d cycles: got %0d expected %0d", req, c,
                 intf_cycles[c*AW +: AW], exp_cyc[c]);
      end
    end
  endtask

  // drive on falling edge, sampled at next rising edge, checked at the falling edge after
  task automatic access(input logic [1:0] core, input logic [15:0] addr,
                        input logic hit, input logic valid);
    @(negedge clk);
    acc_valid = valid; acc_core = core; acc_addr = addr; sc_hit = hit;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic expect_intf(input int core);
    exp_cnt[core] += 1;
    exp_cyc[core] += int'(miss_penalty);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; clr = 1'b0; acc_valid = 1'b0; acc_core = '0; acc_addr = '0;
    sc_hit = 1'b0; miss_penalty = 8'd20;
    for (int c = 0; c < NC; c++) begin exp_cnt[c] = 0; exp_cyc[c] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 reset");

    // table walk
    for (int v = 0; v < NV; v++) begin
      access(VECS[v][19:18], VECS[v][17:2], VECS[v][1], 1'b1);
      if (VECS[v][0]) expect_intf(int'(VECS[v][19:18]));
      check_all($sformatf("R2/R3/R4/R5/R6/R7/R10 vec%0d", v));
    end

    // R9: invalid access must not allocate 0x0910 for core 0
    access(2'd0, 16'h0910, 1'b0, 1'b0);
    check_all("R9 idle no count");
    access(2'd0, 16'h0910, 1'b0, 1'b1);
    check_all("R9 no allocation while idle");

    // R8: penalty taken at access time
    @(negedge clk); miss_penalty = 8'd7;
    access(2'd0, 16'h0110, 1'b0, 1'b1);
    expect_intf(0);
    miss_penalty = 8'd99;
    @(negedge clk);
    check_all("R8 penalty sampled at access");

    // R1: clear zeroes totals and drops shadow lines
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    for (int c = 0; c < NC; c++) begin exp_cnt[c] = 0; exp_cyc[c] = 0; end
    check_all("R1 clear zero");
    access(2'd0, 16'h0110, 1'b0, 1'b1);
    check_all("R1 tags invalid after clear");
    access(2'd0, 16'h0110, 1'b0, 1'b1);
    expect_intf(0);
    check_all("R2 after clear");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule